// File: doc/BRIEF.md
# Dual-Direction Latch/Register Bus Transceiver

This block moves an 18-bit word between two ports, A and B, in both directions at once. Each direction owns a storage word that works in one of three ways. With its latch enable high it passes the input straight through. With the latch enable low it keeps its stored word. With the latch enable low it can also load a new word on a rising edge of its own bus clock, but only while that direction's active-low clock enable is low.

Each output is split into a data word and a drive flag, so no tri-state logic sits inside the block. A drive flag is high only while that direction's active-low output enable was low at the previous sample. The bus clocks, latch enables and enables are all sampled by one system clock, and every result appears one system-clock cycle after the inputs that caused it. A synchronous reset clears both words and turns both drive flags off. This stands in for the high-impedance state while power ramps.

Top module: `dual_path_xcvr`

## Requirements
- R1: While `rst` is high at a `clk` edge, both storage words become zero and both drive flags become 0 after that edge.
- R2: If `ab_le` is 1 at a `clk` edge, `b_out` equals the `a_in` sampled at that edge from then on.
- R3: If `ab_le` is 0 and no bus-clock rising edge is detected, `b_out` keeps its value. A steady high or a steady low on `ab_clk` counts as no edge.
- R4: A rising edge is `ab_clk` sampled 1 at this `clk` edge and 0 at the previous one. When one is detected with `ab_le` = 0 and `ab_clk_en_n` = 0, `a_in` is loaded and shows on `b_out` after that edge.
- R5: A rising edge on `ab_clk` while `ab_clk_en_n` = 1 loads nothing.
- R6: When `ab_le` = 1, a bus-clock edge has no added effect: the output is the transparent value.
- R7: When `ab_le` goes from 1 to 0, `b_out` keeps the last word passed through in transparent mode, even if `a_in` then changes.
- R8: `b_drive` equals the inverse of `ab_oe_n` sampled at the previous `clk` edge: 1 means driving, 0 means high-impedance. The data word is kept while the flag is 0.
- R9: The B-to-A direction works in the same way and on its own, using `b_in`, `ba_le`, `ba_clk`, `ba_clk_en_n` and `ba_oe_n` to produce `a_out` and `a_drive`.
- R10: A bus clock that is already high when reset ends does not count as a rising edge. A load needs a sampled low followed by a sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | 18 | A-side data into the A-to-B path |
| ab_le | input | 1 | A-to-B transparent enable |
| ab_clk | input | 1 | A-to-B bus clock |
| ab_clk_en_n | input | 1 | A-to-B clock qualifier, active low |
| ab_oe_n | input | 1 | B-side drive request, active low |
| b_in | input | 18 | B-side data into the B-to-A path |
| ba_le | input | 1 | B-to-A transparent enable |
| ba_clk | input | 1 | B-to-A bus clock |
| ba_clk_en_n | input | 1 | B-to-A clock qualifier, active low |
| ba_oe_n | input | 1 | A-side drive request, active low |
| b_out | output | 18 | Data word for the B side |
| b_drive | output | 1 | B-side drive flag |
| a_out | output | 18 | Data word for the A side |
| a_drive | output | 1 | A-side drive flag |

## Verification
Every output in this block, whether a transparent pass, a clocked load or a drive flag, is due exactly one system-clock edge after the inputs that cause it. Edge detection looks back at the bus clock sampled one edge earlier, so a load only happens after the clock has been seen low and then high. The driver sets the inputs on the falling clock edge and pushes the expected word for the next rising edge. The monitor reads the outputs a quarter period after that rising edge, so each comparison falls inside the cycle in which the result is valid.

// File: rtl/dual_path_xcvr.sv
module dual_path_xcvr #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  input  logic         ab_le,
  input  logic         ab_clk,
  input  logic         ab_clk_en_n,
  input  logic         ab_oe_n,
  input  logic [W-1:0] b_in,
  input  logic         ba_le,
  input  logic         ba_clk,
  input  logic         ba_clk_en_n,
  input  logic         ba_oe_n,
  output logic [W-1:0] b_out,
  output logic         b_drive,
  output logic [W-1:0] a_out,
  output logic         a_drive
);

  logic [W-1:0] ab_q, ba_q;
  logic         ab_clk_d, ba_clk_d;
  logic         b_en_q, a_en_q;
  logic         ab_load, ba_load;

  assign ab_load = ab_le | (ab_clk & ~ab_clk_d & ~ab_clk_en_n);
  assign ba_load = ba_le | (ba_clk & ~ba_clk_d & ~ba_clk_en_n);

  always_ff @(posedge clk) begin
    if (rst) begin
      ab_q     <= '0;
      ab_clk_d <= 1'b1;
      b_en_q   <= 1'b0;
    end else begin
      if (ab_load) ab_q <= a_in;
      ab_clk_d <= ab_clk;
      b_en_q   <= ~ab_oe_n;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ba_q     <= '0;
      ba_clk_d <= 1'b1;
      a_en_q   <= 1'b0;
    end else begin
      if (ba_load) ba_q <= b_in;
      ba_clk_d <= ba_clk;
      a_en_q   <= ~ba_oe_n;
    end
  end

  assign b_out   = ab_q;
  assign b_drive = b_en_q;
  assign a_out   = ba_q;
  assign a_drive = a_en_q;

endmodule

module dual_path_xcvr_chk #(
  parameter int W = 18
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] a_in,
  input logic         ab_le,
  input logic         ab_clk,
  input logic         ab_clk_en_n,
  input logic         ab_oe_n,
  input logic [W-1:0] b_in,
  input logic         ba_le,
  input logic         ba_clk,
  input logic         ba_clk_en_n,
  input logic         ba_oe_n,
  input logic [W-1:0] b_out,
  input logic         b_drive,
  input logic [W-1:0] a_out,
  input logic         a_drive
);

  logic prev_rst = 1'b1;
  always_ff @(posedge clk) prev_rst <= rst;

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    prev_rst |-> (b_out == '0 && a_out == '0 && !b_drive && !a_drive)); // R1

  AST_AB_TRANSPARENT: assert property (@(posedge clk) disable iff (rst)
    (!prev_rst && $past(ab_le)) |-> (b_out == $past(a_in))); // R2

  AST_AB_HOLD_LOW_CLK: assert property (@(posedge clk) disable iff (rst)
    (!prev_rst && !$past(ab_le) && !$past(ab_clk)) |-> $stable(b_out)); // R3

  AST_AB_GATED: assert property (@(posedge clk) disable iff (rst)
    (!prev_rst && !$past(ab_le) && $past(ab_clk_en_n)) |-> $stable(b_out)); // R5

  AST_B_DRIVE: assert property (@(posedge clk) disable iff (rst)
    !prev_rst |-> (b_drive == !$past(ab_oe_n))); // R8

  AST_A_DRIVE: assert property (@(posedge clk) disable iff (rst)
    !prev_rst |-> (a_drive == !$past(ba_oe_n))); // R9

  AST_BA_TRANSPARENT: assert property (@(posedge clk) disable iff (rst)
    (!prev_rst && $past(ba_le)) |-> (a_out == $past(b_in))); // R9

  AST_BA_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!prev_rst && !$past(ba_le) && (!$past(ba_clk) || $past(ba_clk_en_n))) |-> $stable(a_out)); // R9

endmodule

bind dual_path_xcvr dual_path_xcvr_chk #(.W(W)) u_chk (.*);

// File: tb/dual_path_xcvr_bench.sv
module dual_path_xcvr_bench;
  localparam int W = 18;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic         rst = 1'b1;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic ab_le = 0, ab_clk = 1, ab_clk_en_n = 1, ab_oe_n = 1;
  logic ba_le = 0, ba_clk = 1, ba_clk_en_n = 1, ba_oe_n = 1;
  logic [W-1:0] b_out, a_out;
  logic b_drive, a_drive;

  dual_path_xcvr #(.W(W)) u_dual_path_xcvr (
    .clk(clk), .rst(rst),
    .a_in(a_in), .ab_le(ab_le), .ab_clk(ab_clk), .ab_clk_en_n(ab_clk_en_n), .ab_oe_n(ab_oe_n),
    .b_in(b_in), .ba_le(ba_le), .ba_clk(ba_clk), .ba_clk_en_n(ba_clk_en_n), .ba_oe_n(ba_oe_n),
    .b_out(b_out), .b_drive(b_drive), .a_out(a_out), .a_drive(a_drive)
  );

  typedef struct packed {
    logic [W-1:0] bo;
    logic         bd;
    logic [W-1:0] ao;
    logic         ad;
  } exp_t;

  exp_t  expq[$];
  string tagq[$];
  int    total = 0, bad = 0;
  bit    done = 0;

  logic [W-1:0] m_b = '0, m_a = '0;
  logic m_bd = 0, m_ad = 0, p_ab = 1, p_ba = 1;

  task automatic step(input logic r, input logic [W-1:0] av, input logic le1, input logic c1,
                      input logic ce1, input logic oe1, input logic [W-1:0] bv, input logic le2,
                      input logic c2, input logic ce2, input logic oe2, input string tag);
    @(negedge clk);
    rst = r; a_in = av; ab_le = le1; ab_clk = c1; ab_clk_en_n = ce1; ab_oe_n = oe1;
    b_in = bv; ba_le = le2; ba_clk = c2; ba_clk_en_n = ce2; ba_oe_n = oe2;
    if (r) begin
      m_b = '0; m_a = '0; m_bd = 0; m_ad = 0; p_ab = 1; p_ba = 1;
    end else begin
      if (le1 || (c1 && !p_ab && !ce1)) m_b = av;
      if (le2 || (c2 && !p_ba && !ce2)) m_a = bv;
      p_ab = c1; p_ba = c2;
      m_bd = !oe1; m_ad = !oe2;
    end
    expq.push_back('{bo: m_b, bd: m_bd, ao: m_a, ad: m_ad});
    tagq.push_back(tag);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (expq.size() > 0) begin
        exp_t  e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        total++;
        if (b_out !== e.bo || b_drive !== e.bd || a_out !== e.ao || a_drive !== e.ad) begin
          bad++;
          $display("FAIL %s: got b_out=%h b_drive=%b a_out=%h a_drive=%b exp b_out=%h b_drive=%b a_out=%h a_drive=%b",
                   t, b_out, b_drive, a_out, a_drive, e.bo, e.bd, e.ao, e.ad);
        end
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: got running exp finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1 reset with both bus clocks high
    step(1, 18'h3FFFF, 0, 1, 0, 0, 18'h2AAAA, 0, 1, 0, 0, "R1 reset");
    step(1, 18'h3FFFF, 0, 1, 0, 0, 18'h2AAAA, 0, 1, 0, 0, "R1 reset held");
    // R10 clock already high after reset: no load; R8 drive on
    step(0, 18'h12345, 0, 1, 0, 0, 18'h0F0F0, 0, 1, 0, 0, "R10 no edge after reset");
    step(0, 18'h12345, 0, 0, 0, 0, 18'h0F0F0, 0, 0, 0, 0, "R3 clock low hold");
    // R4 rising edge with enable low
    step(0, 18'h15A5A, 0, 1, 0, 0, 18'h0F0F0, 0, 0, 0, 0, "R4 capture");
    step(0, 18'h00111, 0, 1, 0, 0, 18'h0F0F0, 0, 0, 0, 0, "R3 clock high hold");
    step(0, 18'h00222, 0, 0, 0, 0, 18'h0F0F0, 0, 0, 0, 0, "R3 clock low hold again");
    // R5 gated edge
    step(0, 18'h00333, 0, 1, 1, 0, 18'h0F0F0, 0, 0, 0, 0, "R5 gated edge");
    step(0, 18'h00444, 0, 0, 0, 0, 18'h0F0F0, 0, 0, 0, 0, "R5 gated then low");
    // R2 transparent
    step(0, 18'h2BEEF, 1, 0, 0, 0, 18'h0F0F0, 0, 0, 0, 0, "R2 transparent");
    step(0, 18'h1CAFE, 1, 0, 0, 0, 18'h0F0F0, 0, 0, 0, 0, "R2 transparent follow");
    // R6 edge during transparent
    step(0, 18'h0ABCD, 1, 1, 0, 0, 18'h0F0F0, 0, 0, 0, 0, "R6 edge while transparent");
    // R7 latch enable fall
    step(0, 18'h33333, 0, 1, 0, 0, 18'h0F0F0, 0, 0, 0, 0, "R7 hold after fall");
    step(0, 18'h04444, 0, 0, 0, 0, 18'h0F0F0, 0, 0, 0, 0, "R7 hold data change");
    // R8 output enable high
    step(0, 18'h04444, 0, 0, 0, 1, 18'h0F0F0, 0, 0, 0, 0, "R8 drive off");
    step(0, 18'h04444, 0, 0, 0, 0, 18'h0F0F0, 0, 0, 0, 0, "R8 drive back");
    // R9 B-to-A direction
    step(0, 18'h04444, 0, 0, 0, 0, 18'h1E1E1, 0, 1, 0, 0, "R9 capture B to A");
    step(0, 18'h04444, 0, 0, 0, 0, 18'h3C3C3, 0, 1, 0, 1, "R9 hold and drive off");
    step(0, 18'h04444, 0, 0, 0, 0, 18'h27272, 1, 0, 0, 0, "R9 transparent B to A");
    step(0, 18'h04444, 0, 0, 0, 0, 18'h11111, 0, 0, 1, 0, "R9 hold after fall");
    step(0, 18'h04444, 0, 0, 0, 0, 18'h22222, 0, 1, 1, 0, "R9 gated edge");
    step(0, 18'h04444, 0, 0, 0, 0, 18'h22222, 0, 1, 1, 0, "R9 final");
    repeat (3) @(posedge clk);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule